// File: doc/BRIEF.md
# Single-Channel Dual-Address DMA Engine

The engine moves a block of data from one memory-mapped region to another. It does this one transfer at a time. Each transfer reads from a source address and then writes to a destination address over a simple bus port that has a single master. Software programs the source address, the destination address, a byte count and a control word through a small register write/read port. It then either sets a start bit or lets an external request line trigger the work.

Two run modes are supported:
- **Continuous mode:** one request drains the whole byte count.
- **Cycle-steal mode:** each request moves exactly one transfer.

A programmable bandwidth limit makes the engine let go of the bus for one cycle each time the remaining count lands on a power-of-two boundary. This gives an arbiter the chance to serve another master. When the destination is wider than the source, several narrow reads are packed into one wide write. A bus error in either phase halts the channel and is reported in the status register.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset every register (source, destination, count, control, status) reads zero and `bus_req` is low.
- R2: A transfer is a read cycle at the source address with the source size (`bus_we`=0), followed by a write cycle at the destination address with the destination size (`bus_we`=1) carrying the read data. A cycle completes only on a clock where `bus_gnt` and either `bus_rdy` or `bus_err` are high. Until then, address and direction stay unchanged.
- R3: Size codes are 00=4 bytes, 01=1 byte, 10=2 bytes and 11=reserved. With source increment set (CTRL bit 3), the source address rises by the source size after each successful read. With destination increment set (CTRL bit 4), the destination address rises by the destination size after each successful write. With an increment bit cleared, that address is left unchanged.
- R4: When the destination size is larger than the source size, (destination bytes / source bytes) reads precede each write. The first read fills the lowest byte lanes of the write data.
- R5: Each successful write lowers the count by the destination size, saturating at zero. Reaching zero sets the done flag (STAT bit 0), and no bus cycle follows.
- R6: In continuous mode (CTRL bit 1 = 0), one accepted request keeps the channel transferring until the count reaches zero.
- R7: In cycle-steal mode (CTRL bit 1 = 1), each accepted request performs exactly one transfer and then returns to idle with `bus_req` low.
- R8: The bandwidth field (CTRL bits 11:9) works as follows:
  - A value k other than 0 sets a boundary of 2^(BWC_BASE_LOG2+k-1) bytes.
  - In continuous mode, a write that leaves a nonzero count that is a multiple of the boundary drops `bus_req` for exactly one cycle. The channel then resumes without a new request.
  - A value of 0 never drops the request mid-run.
- R9: A bus error on the read or the write sets the bus-error flag (STAT bit 1) and the done flag. No further bus cycle is issued. A read error suppresses the write, and the failing address is not advanced.
- R10: A request is accepted only while the done flag is clear. It is either a write to CTRL (address 3) with bit 0 set, where the start bit reads back as 0, or `ext_req` high while the external enable (CTRL bit 2) is set. `ext_req` is ignored while that enable is clear. A held `ext_req` in cycle-steal mode repeats transfers.
- R11: The request flag (STAT bit 2) is set when a request is accepted without a configuration error. STAT bit 3 reads 1 while a transfer is in progress. Writing STAT (address 4) with bit 0 set clears the done, bus-error and request flags.
- R12: A request accepted with a reserved size code sets bus-error and done, and leaves the request flag clear. A request accepted with a zero count sets only done. Neither case issues any bus request.
- R13: Register writes to source (0), destination (1), count (2) and control (3) are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 source, 1 destination, 2 count, 3 control, 4 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by `reg_addr` |
| ext_req | input | 1 | External transfer request |
| bus_req | output | 1 | Bus request; high while a cycle is wanted |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Cycle address |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_size | output | 2 | Cycle size code (00 word, 01 byte, 10 half) |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, low lanes used |
| bus_rdy | input | 1 | Cycle completed successfully |
| bus_err | input | 1 | Cycle terminated with an error |

## Verification
The bench targets the following corner cases:
- **Byte-to-word packing.** An off-by-one read counter or a wrong lane offset would emit a write with shifted or stale bytes, and the wrong number of reads.
- **Bandwidth boundary.** The bench counts how often `bus_req` rises during one run for three boundary settings. It also measures the gap length. A design that never released the bus, released it at the final transfer, or held it low for more than one cycle would show a different count or gap.
- **Errors in each phase.** The bench checks that a read error leaves no write behind and that a write error leaves the count untouched.
- **Refused requests.** The bench checks that a start issued while done is set, and an external request issued while the enable is clear, leave the count unchanged.
- **Writes during a run.** The bench checks that a source write in mid-run does not corrupt the final address.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_GAP  = 2'd3
   } dma_state_e;

   // control word as stored, occupying register bits 11:1
   typedef struct packed {
      logic [2:0] bwc;
      logic [1:0] dsize;
      logic [1:0] ssize;
      logic       dinc;
      logic       sinc;
      logic       eext;
      logic       steal;
   } dma_ctrl_t;

   localparam logic [2:0] RA_SRC  = 3'd0;
   localparam logic [2:0] RA_DST  = 3'd1;
   localparam logic [2:0] RA_CNT  = 3'd2;
   localparam logic [2:0] RA_CTRL = 3'd3;
   localparam logic [2:0] RA_STAT = 3'd4;

endpackage

// File: rtl/dma_size_dec.sv
module dma_size_dec (
   input  logic [1:0] code,
   output logic [1:0] lg,
   output logic       rsvd
);
   always_comb begin
      rsvd = 1'b0;
      case (code)
         2'b00:   lg = 2'd2;
         2'b01:   lg = 2'd0;
         2'b10:   lg = 2'd1;
         default: begin
            lg   = 2'd2;
            rsvd = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/dma_packer.sv
module dma_packer #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [1:0]    idx,
   input  logic [1:0]    slg,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] packed_q
);
   localparam int NB = DW / 8;

   logic [1:0]    off;
   logic [3:0]    lmask;
   logic [3:0]    lsel;
   logic [DW-1:0] shifted;

   always_comb begin
      off = 2'(idx << slg);
      case (slg)
         2'd2:    lmask = 4'hF;
         2'd1:    lmask = 4'h3;
         default: lmask = 4'h1;
      endcase
      lsel    = 4'(lmask << off);
      shifted = rdata << {off, 3'b000};
   end

   for (genvar b = 0; b < NB; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            packed_q[b*8 +: 8] <= '0;
         else if (load && lsel[b])
            packed_q[b*8 +: 8] <= shifted[b*8 +: 8];
      end
   end
endmodule

// File: rtl/dma_bw_check.sv
module dma_bw_check #(
   parameter int CW        = 24,
   parameter int BASE_LOG2 = 14,
   parameter bit ENABLE    = 1'b1
) (
   input  logic [2:0]    bwc,
   input  logic [CW-1:0] cnt_next,
   output logic          hit
);
   localparam int LGW = $clog2(CW + 8);

   if (ENABLE) begin : g_bw_on
      logic [LGW-1:0] lg;
      logic [CW-1:0]  mask;
      always_comb begin
         lg   = LGW'(BASE_LOG2) + LGW'(bwc) - LGW'(1);
         mask = ~({CW{1'b1}} << lg);
         hit  = (bwc != 3'd0) && (cnt_next != '0) && ((cnt_next & mask) == '0);
      end
   end else begin : g_bw_off
      assign hit = 1'b0;
   end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
   import dma_xfer_pkg::*;
#(
   parameter int AW            = 32,
   parameter int DW            = 32,
   parameter int CW            = 24,
   parameter int BWC_BASE_LOG2 = 14,
   parameter bit ENABLE_BWC    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          ext_req,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [AW-1:0] bus_addr,
   output logic          bus_we,
   output logic [1:0]    bus_size,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_rdy,
   input  logic          bus_err
);
   if (DW != 32) begin : g_chk_dw
      $error("dma_xfer_engine: DW must be 32");
   end
   if (AW > 32 || AW < 8) begin : g_chk_aw
      $error("dma_xfer_engine: AW must lie in 8..32");
   end
   if (CW > 32 || CW < BWC_BASE_LOG2 + 7) begin : g_chk_cw
      $error("dma_xfer_engine: CW must cover the largest boundary and fit 32 bits");
   end

   dma_state_e    st;
   dma_ctrl_t     ctrl_q;
   logic [AW-1:0] src_q, dst_q;
   logic [CW-1:0] cnt_q;
   logic          st_done, st_bes, st_req;
   logic          start_q;
   logic [1:0]    rd_idx;

   logic [1:0]    sb_lg, db_lg;
   logic          s_rsvd, d_rsvd;
   logic [1:0]    rd_last;
   logic [CW-1:0] dbytes, cnt_next;
   logic          bw_hit, accept, cyc_ok, cyc_err, busy_w, stat_clr;

   dma_size_dec u_sdec (.code(ctrl_q.ssize), .lg(sb_lg), .rsvd(s_rsvd));
   dma_size_dec u_ddec (.code(ctrl_q.dsize), .lg(db_lg), .rsvd(d_rsvd));

   dma_packer #(.DW(DW)) u_pack (
      .clk(clk), .rst_n(rst_n),
      .load(st == ST_RD && cyc_ok),
      .idx(rd_idx), .slg(sb_lg),
      .rdata(bus_rdata), .packed_q(bus_wdata)
   );

   dma_bw_check #(.CW(CW), .BASE_LOG2(BWC_BASE_LOG2), .ENABLE(ENABLE_BWC)) u_bw (
      .bwc(ctrl_q.bwc), .cnt_next(cnt_next), .hit(bw_hit)
   );

   always_comb begin
      busy_w   = (st != ST_IDLE);
      rd_last  = (db_lg > sb_lg) ? 2'((3'd1 << (db_lg - sb_lg)) - 3'd1) : 2'd0;
      dbytes   = CW'(3'd1 << db_lg);
      cnt_next = (cnt_q <= dbytes) ? '0 : cnt_q - dbytes;
      accept   = !st_done && (start_q || (ctrl_q.eext && ext_req));
      cyc_ok   = bus_gnt && bus_rdy && !bus_err;
      cyc_err  = bus_gnt && bus_err;
      stat_clr = reg_wr && reg_addr == RA_STAT && reg_wdata[0];

      bus_req  = (st == ST_RD) || (st == ST_WR);
      bus_we   = (st == ST_WR);
      bus_addr = (st == ST_WR) ? dst_q : src_q;
      bus_size = (st == ST_WR) ? ctrl_q.dsize : ctrl_q.ssize;

      case (reg_addr)
         RA_SRC:  reg_rdata = 32'(src_q);
         RA_DST:  reg_rdata = 32'(dst_q);
         RA_CNT:  reg_rdata = 32'(cnt_q);
         RA_CTRL: reg_rdata = {20'd0, ctrl_q, 1'b0};
         RA_STAT: reg_rdata = {28'd0, busy_w, st_req, st_bes, st_done};
         default: reg_rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ctrl_q  <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         st_done <= 1'b0;
         st_bes  <= 1'b0;
         st_req  <= 1'b0;
         start_q <= 1'b0;
         rd_idx  <= '0;
      end else begin
         start_q <= 1'b0;
         if (reg_wr && st == ST_IDLE) begin
            case (reg_addr)
               RA_SRC:  src_q  <= reg_wdata[AW-1:0];
               RA_DST:  dst_q  <= reg_wdata[AW-1:0];
               RA_CNT:  cnt_q  <= reg_wdata[CW-1:0];
               RA_CTRL: begin
                  ctrl_q  <= reg_wdata[11:1];
                  start_q <= reg_wdata[0];
               end
               default: ;
            endcase
         end
         if (stat_clr) begin
            st_done <= 1'b0;
            st_bes  <= 1'b0;
            st_req  <= 1'b0;
         end

         case (st)
            ST_IDLE: if (accept) begin
               if (s_rsvd || d_rsvd) begin
                  st_bes  <= 1'b1;
                  st_done <= 1'b1;
               end else if (cnt_q == '0) begin
                  st_done <= 1'b1;
               end else begin
                  st_req <= 1'b1;
                  rd_idx <= '0;
                  st     <= ST_RD;
               end
            end
            ST_RD: if (cyc_err) begin
               st_bes  <= 1'b1;
               st_done <= 1'b1;
               st      <= ST_IDLE;
            end else if (cyc_ok) begin
               if (ctrl_q.sinc) src_q <= src_q + AW'(3'd1 << sb_lg);
               if (rd_idx == rd_last) st <= ST_WR;
               else                   rd_idx <= rd_idx + 2'd1;
            end
            ST_WR: if (cyc_err) begin
               st_bes  <= 1'b1;
               st_done <= 1'b1;
               st      <= ST_IDLE;
            end else if (cyc_ok) begin
               if (ctrl_q.dinc) dst_q <= dst_q + AW'(3'd1 << db_lg);
               cnt_q  <= cnt_next;
               rd_idx <= '0;
               if (cnt_next == '0) begin
                  st_done <= 1'b1;
                  st      <= ST_IDLE;
               end else if (ctrl_q.steal) st <= ST_IDLE;
               else if (bw_hit)           st <= ST_GAP;
               else                       st <= ST_RD;
            end
            ST_GAP:  st <= ST_RD;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
   parameter int AW = 32,
   parameter int CW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic          bus_rdy,
   input logic          bus_err,
   input logic [AW-1:0] bus_addr,
   input logic          bus_we,
   input logic          busy,
   input logic          done,
   input logic [CW-1:0] cnt
);
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !(bus_gnt && (bus_rdy || bus_err)) |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R2
   AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_gnt && bus_err |=> !bus_req && done); // R9
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req); // R5
   AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !bus_req |=> bus_req); // R8
   AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> cnt <= $past(cnt)); // R13
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
   .bus_rdy(bus_rdy), .bus_err(bus_err), .bus_addr(bus_addr), .bus_we(bus_we),
   .busy(busy_w), .done(st_done), .cnt(cnt_q)
);

// File: tb/dma_xfer_engine_tb_top.sv
module dma_xfer_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32, DW = 32, CW = 24, BASE = 4;

   logic          clk, rst_n, reg_wr, ext_req;
   logic [2:0]    reg_addr;
   logic [31:0]   reg_wdata, reg_rdata;
   logic          bus_req, bus_gnt, bus_we, bus_rdy, bus_err;
   logic [AW-1:0] bus_addr;
   logic [1:0]    bus_size;
   logic [DW-1:0] bus_wdata, bus_rdata;

   dma_xfer_engine #(.AW(AW), .DW(DW), .CW(CW), .BWC_BASE_LOG2(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rdy(bus_rdy), .bus_err(bus_err)
   );

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] d;
      logic [1:0]  sz;
   } exp_t;

   exp_t       expq[$];
   logic [7:0] mem [0:255];
   int nchk = 0, nfail = 0;
   int n_rd = 0, n_wr = 0, rises = 0, lowlen = 0, gaplen = 0;
   int wait_cfg = 0, wait_cnt = 0;
   bit gnt_toggle = 0, err_en = 0, prev_req = 0, finished = 0;
   logic [31:0] err_addr = '0;

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   function automatic int sz2b(input logic [1:0] c);
      return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 4;
   endfunction

   function automatic logic [31:0] lanemask(input int n);
      return (n >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*n)) - 32'd1);
   endfunction

   function automatic logic [31:0] mk(input bit start, input bit cs, input bit eext,
                                      input bit sinc, input bit dinc, input logic [1:0] ss,
                                      input logic [1:0] ds, input logic [2:0] bwc);
      return {20'd0, bwc, ds, ss, dinc, sinc, eext, cs, start};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bus responder and scoreboard monitor
   always @(negedge clk) begin
      bus_rdy = 1'b0;
      bus_err = 1'b0;
      bus_gnt = gnt_toggle ? ~bus_gnt : 1'b1;
      if (bus_req && !prev_req) begin
         if (rises > 0) gaplen = lowlen;
         rises++;
         lowlen = 0;
      end
      if (!bus_req) lowlen++;
      prev_req = bus_req;
      if (rst_n && bus_req && bus_gnt) begin
         if (wait_cnt < wait_cfg) wait_cnt++;
         else begin
            wait_cnt = 0;
            if (err_en && bus_addr == err_addr) bus_err = 1'b1;
            else begin
               bus_rdy = 1'b1;
               if (!bus_we) begin
                  n_rd++;
                  bus_rdata = '0;
                  for (int b = 0; b < sz2b(bus_size); b++)
                     bus_rdata[b*8 +: 8] = mem[8'(bus_addr[7:0] + 8'(b))];
               end else begin
                  n_wr++;
                  for (int b = 0; b < sz2b(bus_size); b++)
                     mem[8'(bus_addr[7:0] + 8'(b))] = bus_wdata[b*8 +: 8];
                  if (expq.size() == 0) chk(1'b0, "R2 unexpected write", bus_addr, 32'hFFFF_FFFF);
                  else begin
                     exp_t e;
                     e = expq.pop_front();
                     chk(bus_addr == e.a, "R3 write address", bus_addr, e.a);
                     chk(bus_size == e.sz, "R2 write size", 32'(bus_size), 32'(e.sz));
                     chk((bus_wdata & lanemask(sz2b(e.sz))) == e.d, "R4 write data",
                         bus_wdata & lanemask(sz2b(e.sz)), e.d);
                  end
               end
            end
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 5000; i++) begin
         rd(3'd4, v);
         if (!v[3]) break;
      end
   endtask

   // driver: pushes the expected writes of up to n transfers
   task automatic push_xfers(input int n, input logic [1:0] ss, input logic [1:0] ds,
                             input bit sinc, input bit dinc,
                             inout logic [31:0] s, inout logic [31:0] d, inout logic [31:0] c);
      int sb, db, nrd;
      logic [31:0] data;
      exp_t e;
      sb = sz2b(ss); db = sz2b(ds);
      nrd = (db > sb) ? db / sb : 1;
      for (int t = 0; t < n && c != 0; t++) begin
         data = '0;
         for (int k = 0; k < nrd; k++) begin
            for (int b = 0; b < sb; b++)
               if (k*sb + b < 4) data[(k*sb + b)*8 +: 8] = mem[8'(s[7:0] + 8'(b))];
            if (sinc) s = s + 32'(sb);
         end
         e.a = d; e.d = data & lanemask(db); e.sz = ds;
         expq.push_back(e);
         if (dinc) d = d + 32'(db);
         c = (c <= 32'(db)) ? 32'd0 : c - 32'(db);
      end
   endtask

   task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
      wr(3'd0, s); wr(3'd1, d); wr(3'd2, c);
      n_rd = 0; n_wr = 0; rises = 0; gaplen = 0;
   endtask

   task automatic bw_run(input logic [2:0] bwc, input int exp_rises);
      logic [31:0] s, d, c, v;
      s = 32'h00; d = 32'hC0; c = 32'd48;
      setup(s, d, c);
      push_xfers(100, 2'b00, 2'b00, 1, 1, s, d, c);
      wr(3'd3, mk(1, 0, 0, 1, 1, 2'b00, 2'b00, bwc));
      wait_idle();
      chk(rises == exp_rises, "R8 bus request rises", 32'(rises), 32'(exp_rises));
      if (exp_rises > 1) chk(gaplen == 1, "R8 gap length", 32'(gaplen), 32'd1);
      chk(expq.size() == 0, "R6 all writes seen", 32'(expq.size()), 0);
      rd(3'd2, v); chk(v == 0, "R6 count drained", v, 0);
      wr(3'd4, 32'd1);
   endtask

   initial begin
      logic [31:0] v, s, d, c;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i*13 + 5);
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; ext_req = 1'b0;
      bus_rdata = '0; bus_rdy = 1'b0; bus_err = 1'b0; bus_gnt = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         chk(v == 0, "R1 register reset", v, 0);
      end
      chk(bus_req == 1'b0, "R1 bus_req reset", 32'(bus_req), 0);

      // R2 R3 R5 R6 word copy, continuous
      s = 32'h00; d = 32'h80; c = 32'd16;
      setup(s, d, c);
      push_xfers(100, 2'b00, 2'b00, 1, 1, s, d, c);
      wr(3'd3, mk(1, 0, 0, 1, 1, 2'b00, 2'b00, 3'd0));
      wait_idle();
      rd(3'd0, v); chk(v == 32'h10, "R3 source advanced", v, 32'h10);
      rd(3'd1, v); chk(v == 32'h90, "R3 destination advanced", v, 32'h90);
      rd(3'd2, v); chk(v == 0, "R5 count zero", v, 0);
      rd(3'd4, v); chk(v == 32'h5, "R5 done and R11 request flag", v, 32'h5);
      rd(3'd3, v); chk(v[0] == 1'b0, "R10 start bit reads zero", v, 0);
      chk(n_wr == 4 && expq.size() == 0, "R6 four writes", 32'(n_wr), 4);
      wr(3'd4, 32'd1);
      rd(3'd4, v); chk(v == 0, "R11 status cleared", v, 0);

      // R4 byte reads packed into words
      s = 32'h20; d = 32'hA0; c = 32'd8;
      setup(s, d, c);
      push_xfers(100, 2'b01, 2'b00, 1, 1, s, d, c);
      wr(3'd3, mk(1, 0, 0, 1, 1, 2'b01, 2'b00, 3'd0));
      wait_idle();
      chk(n_rd == 8, "R4 read count", 32'(n_rd), 8);
      chk(n_wr == 2, "R4 write count", 32'(n_wr), 2);
      rd(3'd0, v); chk(v == 32'h28, "R3 byte source step", v, 32'h28);
      wr(3'd4, 32'd1);

      // R3 fixed destination, with stalls, R13 write during run
      s = 32'h30; d = 32'hB0; c = 32'd6;
      setup(s, d, c);
      push_xfers(100, 2'b10, 2'b10, 1, 0, s, d, c);
      wait_cfg = 2; gnt_toggle = 1;
      wr(3'd3, mk(1, 0, 0, 1, 0, 2'b10, 2'b10, 3'd0));
      repeat (4) @(negedge clk);
      wr(3'd0, 32'h77);
      wr(3'd2, 32'h40);
      wait_idle();
      wait_cfg = 0; gnt_toggle = 0;
      repeat (2) @(negedge clk);
      rd(3'd1, v); chk(v == 32'hB0, "R3 fixed destination", v, 32'hB0);
      rd(3'd0, v); chk(v == 32'h36, "R13 source write ignored", v, 32'h36);
      rd(3'd2, v); chk(v == 0, "R13 count write ignored", v, 0);
      chk(n_wr == 3 && expq.size() == 0, "R2 stalled writes", 32'(n_wr), 3);
      wr(3'd4, 32'd1);

      // R8 bandwidth boundaries
      bw_run(3'd1, 3);
      bw_run(3'd2, 2);
      bw_run(3'd0, 1);

      // R7 cycle steal
      s = 32'h40; d = 32'h60; c = 32'd12;
      setup(s, d, c);
      push_xfers(1, 2'b00, 2'b00, 1, 1, s, d, c);
      wr(3'd3, mk(1, 1, 0, 1, 1, 2'b00, 2'b00, 3'd0));
      wait_idle();
      rd(3'd2, v); chk(v == 8, "R7 one transfer per request", v, 8);
      rd(3'd4, v); chk(v == 32'h4, "R7 not done after steal", v, 32'h4);
      push_xfers(1, 2'b00, 2'b00, 1, 1, s, d, c);
      wr(3'd3, mk(1, 1, 0, 1, 1, 2'b00, 2'b00, 3'd0));
      wait_idle();
      rd(3'd2, v); chk(v == 4, "R7 second steal", v, 4);

      // R10 external request gated by enable
      n_wr = 0;
      ext_req = 1'b1;
      repeat (20) @(negedge clk);
      rd(3'd2, v); chk(v == 4, "R10 ext_req ignored without enable", v, 4);
      chk(n_wr == 0, "R10 no write without enable", 32'(n_wr), 0);
      push_xfers(1, 2'b00, 2'b00, 1, 1, s, d, c);
      wr(3'd3, mk(0, 1, 1, 1, 1, 2'b00, 2'b00, 3'd0));
      wait_idle();
      repeat (20) @(negedge clk);
      ext_req = 1'b0;
      chk(n_wr == 1 && expq.size() == 0, "R10 held ext_req runs to done", 32'(n_wr), 1);
      rd(3'd4, v); chk(v == 32'h5, "R10 done after external run", v, 32'h5);
      wr(3'd3, mk(0, 0, 0, 1, 1, 2'b00, 2'b00, 3'd0));
      setup(32'h0, 32'h80, 32'd8);
      wr(3'd3, mk(1, 0, 0, 1, 1, 2'b00, 2'b00, 3'd0));
      repeat (10) @(negedge clk);
      rd(3'd2, v); chk(v == 8, "R10 start ignored while done", v, 8);
      chk(n_wr == 0, "R10 no bus while done", 32'(n_wr), 0);
      wr(3'd4, 32'd1);

      // R9 read error
      s = 32'h00; d = 32'h80; c = 32'd8;
      setup(s, d, c);
      push_xfers(1, 2'b00, 2'b00, 1, 1, s, d, c);
      err_en = 1; err_addr = 32'h04;
      wr(3'd3, mk(1, 0, 0, 1, 1, 2'b00, 2'b00, 3'd0));
      wait_idle();
      rd(3'd4, v); chk(v == 32'h7, "R9 read error flags", v, 32'h7);
      chk(n_wr == 1 && expq.size() == 0, "R9 no write after read error", 32'(n_wr), 1);
      rd(3'd0, v); chk(v == 32'h04, "R9 source held on error", v, 32'h04);
      rd(3'd2, v); chk(v == 4, "R9 count after read error", v, 4);
      wr(3'd4, 32'd1);

      // R9 write error
      setup(32'h00, 32'h80, 32'd8);
      err_addr = 32'h80;
      wr(3'd3, mk(1, 0, 0, 1, 1, 2'b00, 2'b00, 3'd0));
      wait_idle();
      err_en = 0;
      rd(3'd4, v); chk(v == 32'h7, "R9 write error flags", v, 32'h7);
      rd(3'd2, v); chk(v == 8, "R9 count kept on write error", v, 8);
      chk(n_wr == 0, "R9 failed write not counted", 32'(n_wr), 0);
      wr(3'd4, 32'd1);

      // R12 reserved size and zero count
      setup(32'h00, 32'h80, 32'd8);
      wr(3'd3, mk(1, 0, 0, 1, 1, 2'b11, 2'b00, 3'd0));
      repeat (5) @(negedge clk);
      rd(3'd4, v); chk(v == 32'h3, "R12 reserved size error", v, 32'h3);
      chk(rises == 0, "R12 no bus on reserved size", 32'(rises), 0);
      wr(3'd4, 32'd1);
      setup(32'h00, 32'h80, 32'd0);
      wr(3'd3, mk(1, 0, 0, 1, 1, 2'b00, 2'b00, 3'd0));
      repeat (5) @(negedge clk);
      rd(3'd4, v); chk(v == 32'h1, "R12 zero count done", v, 32'h1);
      chk(rises == 0, "R12 no bus on zero count", 32'(rises), 0);

      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end
endmodule